// File: doc/BRIEF.md
# Delayed Read Termination Handler

This block sits on the target-bus side of a bus bridge. A delayed read has been forwarded to the target, and the target has ended it. The block decides what happens next. It can issue the same read to the target again, complete it toward the waiting initiator (plainly or with a disconnect), or pass an abort back. The code for that decision is presented on the cycle after the termination is reported.

The block also counts how many times the current delayed read has been retried. Once the count reaches a parameterised limit (16,777,216 by default), it can request a system error. That request depends on an enable bit being set and a separate non-delivery disable bit being clear. The abort status bits that software keeps elsewhere are driven through one-cycle set pulses, so the status register can use write-one-to-clear semantics.

Top module: `drd_term_handler`

## Requirements
- R1: A reported termination with `term_type_i` = 2'b01 (target retry) drives `reissue_o` high for the following cycle, and `resp_o` stays 2'b00 (no response) in that cycle.
- R2: Termination types are 2'b00 normal completion, 2'b01 retry, 2'b10 target disconnect and 2'b11 target abort. Response codes are 2'b00 none, 2'b01 normal, 2'b10 disconnect and 2'b11 abort. Every output is registered and appears exactly one cycle after `term_valid_i`. With no termination reported, all outputs are zero.
- R3: A normal completion of a non-prefetchable read (`prefetch_i` = 0) yields a disconnect (2'b10), whatever the data counts are.
- R4: A normal completion of a prefetchable read yields a disconnect when `req_cnt_i` > `got_cnt_i`, and a normal response (2'b01) otherwise.
- R5: A target disconnect yields a disconnect when `req_cnt_i` > `got_cnt_i`, and a normal response otherwise. Prefetchability does not change this.
- R6: A target abort yields response 2'b11. In the same cycle it pulses both `rx_abort_set_o` (target-side status) and `tx_abort_set_o` (initiator-side status) for exactly one cycle.
- R7: The retry whose count, since the last `load_i` or non-retry termination, equals `ATT_LIMIT` produces a one-cycle `serr_o` pulse. Earlier retries produce none.
- R8: Retries after the limit produce no further `serr_o`. A `load_i` pulse or any non-retry termination restarts the count from zero.
- R9: `serr_o` fires only if `serr_en_i` = 1 and `nodeliv_dis_i` = 0 on the limit-reaching retry. A limit reached while gated stays silent, and later retries of that read never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | A new delayed read is loaded; restarts the attempt count |
| term_valid_i | input | 1 | A target termination is reported this cycle |
| term_type_i | input | 2 | Termination type |
| prefetch_i | input | 1 | The read is prefetchable |
| req_cnt_i | input | CNT_W | Data units the initiator asks for |
| got_cnt_i | input | CNT_W | Data units read from the target |
| serr_en_i | input | 1 | System-error enable bit |
| nodeliv_dis_i | input | 1 | Non-delivery system-error disable bit |
| reissue_o | output | 1 | Issue the same read to the target again |
| resp_o | output | 2 | Response code to the initiator |
| rx_abort_set_o | output | 1 | Set pulse for the received-target-abort status bit |
| tx_abort_set_o | output | 1 | Set pulse for the signaled-target-abort status bit |
| serr_o | output | 1 | System-error request pulse |

## Verification
The bench builds the block with `ATT_LIMIT` = 4 and `CNT_W` = 8. With those values the limit-reaching retry, the retries after it and a restart in mid-count can all be reached in a few dozen cycles, rather than after sixteen million retries. The 8-bit counts keep the equal, greater and smaller comparisons of requested against delivered data easy to exercise. Because the counter compare is the same logic at the default limit, the short limit only changes how soon it is reached.

// File: rtl/drd_pkg.sv
package drd_pkg;
  typedef enum logic [1:0] {
    TERM_DONE  = 2'b00,
    TERM_RETRY = 2'b01,
    TERM_DISC  = 2'b10,
    TERM_ABORT = 2'b11
  } term_e;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'b00,
    RSP_NORM  = 2'b01,
    RSP_DISC  = 2'b10,
    RSP_ABORT = 2'b11
  } resp_e;
endpackage

// File: rtl/drd_resp_dec.sv
module drd_resp_dec
  import drd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             valid_i,
  input  logic [1:0]       type_i,
  input  logic             prefetch_i,
  input  logic [CNT_W-1:0] req_i,
  input  logic [CNT_W-1:0] got_i,
  output logic [1:0]       resp_o,
  output logic             reissue_o,
  output logic             abort_o
);
  logic short_data;
  assign short_data = req_i > got_i;

  always_comb begin
    resp_o    = RSP_NONE;
    reissue_o = 1'b0;
    abort_o   = 1'b0;
    if (valid_i) begin
      unique case (type_i)
        TERM_DONE:  resp_o = (!prefetch_i || short_data) ? RSP_DISC : RSP_NORM;
        TERM_RETRY: reissue_o = 1'b1;
        TERM_DISC:  resp_o = short_data ? RSP_DISC : RSP_NORM;
        TERM_ABORT: begin
          resp_o  = RSP_ABORT;
          abort_o = 1'b1;
        end
        default: resp_o = RSP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/drd_attempt_ctr.sv
module drd_attempt_ctr #(
  parameter longint ATT_LIMIT = 64'd16777216,
  parameter int     ATT_W     = $clog2(ATT_LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic bump_i,
  output logic hit_o
);
  localparam logic [ATT_W-1:0] LAST = ATT_W'(ATT_LIMIT - 1);

  logic [ATT_W-1:0] cnt_q;
  logic             spent_q;

  // count stops once the limit has been reached; spent_q blocks a second hit
  assign hit_o = bump_i && !clear_i && !spent_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      spent_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q   <= '0;
      spent_q <= 1'b0;
    end else if (bump_i && !spent_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) spent_q <= 1'b1;
    end
  end
endmodule

// File: rtl/drd_term_handler.sv
module drd_term_handler
  import drd_pkg::*;
#(
  parameter int     CNT_W     = 16,
  parameter longint ATT_LIMIT = 64'd16777216
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             term_valid_i,
  input  logic [1:0]       term_type_i,
  input  logic             prefetch_i,
  input  logic [CNT_W-1:0] req_cnt_i,
  input  logic [CNT_W-1:0] got_cnt_i,
  input  logic             serr_en_i,
  input  logic             nodeliv_dis_i,
  output logic             reissue_o,
  output logic [1:0]       resp_o,
  output logic             rx_abort_set_o,
  output logic             tx_abort_set_o,
  output logic             serr_o
);
  localparam int ATT_W = $clog2(ATT_LIMIT + 1);

  logic [1:0] resp_d;
  logic       reissue_d, abort_d, hit, retry_seen, finish_seen;

  drd_resp_dec #(.CNT_W(CNT_W)) i_dec (
    .valid_i    (term_valid_i),
    .type_i     (term_type_i),
    .prefetch_i (prefetch_i),
    .req_i      (req_cnt_i),
    .got_i      (got_cnt_i),
    .resp_o     (resp_d),
    .reissue_o  (reissue_d),
    .abort_o    (abort_d)
  );

  assign retry_seen  = term_valid_i && (term_type_i == TERM_RETRY);
  assign finish_seen = term_valid_i && (term_type_i != TERM_RETRY);

  drd_attempt_ctr #(.ATT_LIMIT(ATT_LIMIT), .ATT_W(ATT_W)) i_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load_i || finish_seen),
    .bump_i  (retry_seen),
    .hit_o   (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reissue_o      <= 1'b0;
      resp_o         <= RSP_NONE;
      rx_abort_set_o <= 1'b0;
      tx_abort_set_o <= 1'b0;
      serr_o         <= 1'b0;
    end else begin
      reissue_o      <= reissue_d;
      resp_o         <= resp_d;
      rx_abort_set_o <= abort_d;
      tx_abort_set_o <= abort_d;
      serr_o         <= hit && serr_en_i && !nodeliv_dis_i;
    end
  end
endmodule

// File: rtl/drd_term_handler_chk.sv
module drd_term_handler_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             term_valid_i,
  input logic [1:0]       term_type_i,
  input logic             prefetch_i,
  input logic             serr_en_i,
  input logic             nodeliv_dis_i,
  input logic             reissue_o,
  input logic [1:0]       resp_o,
  input logic             rx_abort_set_o,
  input logic             tx_abort_set_o,
  input logic             serr_o
);
  a_r1_retry_reissue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_valid_i && term_type_i == 2'b01) |=> (reissue_o && resp_o == 2'b00));

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !term_valid_i |=> (resp_o == 2'b00 && !reissue_o && !rx_abort_set_o && !tx_abort_set_o));

  a_r3_nonpf_disc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_valid_i && term_type_i == 2'b00 && !prefetch_i) |=> (resp_o == 2'b10));

  a_r6_abort_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_valid_i && term_type_i == 2'b11) |=> (resp_o == 2'b11 && rx_abort_set_o && tx_abort_set_o));

  a_r8_serr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_o |=> !serr_o);

  a_r9_serr_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_o |-> ($past(serr_en_i) && !$past(nodeliv_dis_i) && $past(term_valid_i)));
endmodule

bind drd_term_handler drd_term_handler_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .term_valid_i   (term_valid_i),
  .term_type_i    (term_type_i),
  .prefetch_i     (prefetch_i),
  .serr_en_i      (serr_en_i),
  .nodeliv_dis_i  (nodeliv_dis_i),
  .reissue_o      (reissue_o),
  .resp_o         (resp_o),
  .rx_abort_set_o (rx_abort_set_o),
  .tx_abort_set_o (tx_abort_set_o),
  .serr_o         (serr_o)
);

// File: tb/test_drd_term_handler.sv
module test_drd_term_handler;
  localparam int CNT_W = 8;
  localparam longint LIMIT = 64'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0, tv = 1'b0, pf = 1'b0, sen = 1'b1, sdis = 1'b0;
  logic [1:0] tt = 2'b00;
  logic [CNT_W-1:0] req = '0, got = '0;
  logic reissue, rxa, txa, serr;
  logic [1:0] resp;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  drd_term_handler #(.CNT_W(CNT_W), .ATT_LIMIT(LIMIT)) i_drd_term_handler (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .term_valid_i(tv), .term_type_i(tt),
    .prefetch_i(pf), .req_cnt_i(req), .got_cnt_i(got), .serr_en_i(sen),
    .nodeliv_dis_i(sdis), .reissue_o(reissue), .resp_o(resp),
    .rx_abort_set_o(rxa), .tx_abort_set_o(txa), .serr_o(serr)
  );

  // {type, prefetch, req, got, exp_resp, exp_reissue, exp_abort}
  localparam int NV = 9;
  localparam logic [22:0] VEC [NV] = '{
    {2'b00, 1'b1, 8'd4, 8'd4, 2'b01, 1'b0, 1'b0},  // R4 equal -> normal
    {2'b00, 1'b1, 8'd9, 8'd4, 2'b10, 1'b0, 1'b0},  // R4 more -> disc
    {2'b00, 1'b1, 8'd2, 8'd4, 2'b01, 1'b0, 1'b0},  // R4 less -> normal
    {2'b00, 1'b0, 8'd1, 8'd1, 2'b10, 1'b0, 1'b0},  // R3
    {2'b00, 1'b0, 8'd0, 8'd7, 2'b10, 1'b0, 1'b0},  // R3
    {2'b10, 1'b0, 8'd5, 8'd3, 2'b10, 1'b0, 1'b0},  // R5 more
    {2'b10, 1'b1, 8'd3, 8'd3, 2'b01, 1'b0, 1'b0},  // R5 equal
    {2'b11, 1'b0, 8'd1, 8'd1, 2'b11, 1'b0, 1'b1},  // R6
    {2'b01, 1'b1, 8'd1, 8'd0, 2'b00, 1'b1, 1'b0}   // R1
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one cycle, sample the registered result on the next falling edge
  task automatic term(input logic [1:0] t, input logic p, input logic [7:0] r, input logic [7:0] g);
    @(negedge clk);
    tv = 1'b1; tt = t; pf = p; req = r; got = g;
    @(negedge clk);
    tv = 1'b0;
  endtask

  task automatic retry_n(input int n, input string tag, input logic exp_serr_last);
    for (int k = 0; k < n; k++) begin
      term(2'b01, 1'b0, 8'd0, 8'd0);
      check(tag, serr, (k == n - 1) ? exp_serr_last : 1'b0);
    end
  endtask

  task automatic do_load();
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2 reset resp", resp, 2'b00);
    check("R2 reset pulses", {reissue, rxa, txa, serr}, 4'b0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      term(v[22:21], v[20], v[19:12], v[11:4]);
      check($sformatf("R2 vec%0d resp (R1/R3/R4/R5/R6)", i), resp, v[3:2]);
      check($sformatf("R1 vec%0d reissue", i), reissue, v[1]);
      check($sformatf("R6 vec%0d abort set", i), {rxa, txa}, {2{v[0]}});
    end

    // R2 idle cycle: outputs return to zero, R6 pulse is one cycle
    @(negedge clk);
    check("R2 idle", {resp, reissue, rxa, txa, serr}, 6'd0);

    // R7 limit-reaching retry raises serr; R8 no second pulse
    do_load();
    retry_n(4, "R7 limit", 1'b1);
    retry_n(2, "R8 after limit", 1'b0);
    check("R1 reissue continues", reissue, 1'b1);

    // R8 non-retry termination restarts the count
    do_load();
    retry_n(3, "R8 pre-finish", 1'b0);
    term(2'b00, 1'b1, 8'd1, 8'd1);
    retry_n(3, "R8 after finish", 1'b0);
    retry_n(1, "R8 new limit", 1'b1);

    // R8 load in mid-count restarts
    do_load();
    retry_n(2, "R8 pre-load", 1'b0);
    do_load();
    retry_n(3, "R8 after load", 1'b0);
    retry_n(1, "R8 limit after load", 1'b1);

    // R9 disabled by enable bit; later retries stay silent once enabled
    do_load();
    sen = 1'b0;
    retry_n(4, "R9 enable clear", 1'b0);
    sen = 1'b1;
    retry_n(2, "R9 spent stays silent", 1'b0);

    // R9 disable bit set
    do_load();
    sdis = 1'b1;
    retry_n(4, "R9 disable set", 1'b0);
    sdis = 1'b0;

    // R7 abort clears count too
    do_load();
    retry_n(3, "R7 pre-abort", 1'b0);
    term(2'b11, 1'b0, 8'd0, 8'd0);
    check("R6 abort resp", resp, 2'b11);
    retry_n(4, "R7 limit after abort", 1'b1);

    @(negedge clk);
    check("R8 serr one cycle", serr, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule